// File: doc/BRIEF.md
# Nonvolatile Byte Store Command Controller

This block gives software byte-wide access to a nonvolatile store through two 32-bit registers. A command register holds an operation code, a 13-bit byte address, a start/busy bit and a sticky timeout flag. A data register holds the byte to be written or the byte most recently fetched. Software sets the busy bit to launch a command. The controller then raises a request to the store backend and waits for its acknowledge. When the command ends, the controller drops busy by itself.

The backend in this project is a byte array with a latency taken from an input port. A presence input can hold it silent. A cycle watchdog runs for every command. If no acknowledge arrives within `TIMEOUT_CYCLES` cycles of launch, the watchdog drops the request, clears busy and sets the timeout flag. Software can probe for the store by launching any command. The store counts as fitted when busy clears and the timeout flag stays low.

Top module: `nvm_cmd_ctrl`

## Requirements
- R1: After reset, the command register and the data register both read as zero.
- R2: A command-register write (offset 0x0) with bit 31 set, made while idle, launches a command. Bit 31 then reads 1 for exactly latency+2 cycles and then reads 0 again.
- R3: The operation code sits in bits 29:28. The value 2'b11 writes data-register bits 7:0 to the addressed byte. Any other value reads the addressed byte into data-register bits 7:0, and bits 31:8 of the data register read as zero.
- R4: The command register reads back busy in bit 31, the operation code in bits 29:28, the timeout flag in bit 17 and the address in bits 12:0. All other bits read as zero.
- R5: When the store does not acknowledge within TIMEOUT_CYCLES cycles, busy clears after exactly TIMEOUT_CYCLES cycles, bit 17 goes to 1, and the data register keeps its value.
- R6: Bit 17 clears only when software writes a 1 to it. Writing a 0 to bit 17 leaves the flag unchanged. If expiry and clear happen in the same cycle, expiry wins.
- R7: While busy, a command-register write changes neither the operation code nor the address and does not start a command. A 1 written to bit 17 still clears the timeout flag.
- R8: A data-register write (offset 0x4) made while busy is ignored.
- R9: A probe of an absent store ends with bit 17 set. A probe of a fitted store with latency+2 no greater than TIMEOUT_CYCLES ends with bit 17 clear.
- R10: The store model keeps STORE_DEPTH bytes. A byte address is taken modulo STORE_DEPTH.
- R11: A command write with bit 31 clear latches the operation code and the address but starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register offset: 0x0 command, 0x4 data |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data of the register at bus_addr, combinational |
| store_fitted | input | 1 | Store model responds when high |
| store_latency | input | 8 | Wait cycles the store model adds before it acknowledges |

## Verification
Byte writes and reads run with store latencies of 0, 3 and the largest value that still beats the watchdog. These runs show that the busy length follows the latency and not a fixed count, and that an acknowledge arriving on the watchdog's last cycle still counts as success. A latency past the limit and an absent store each show that expiry leaves the fetched byte untouched. Writes made during busy, aimed at either register, show which fields are frozen and that the timeout clear still works. A read at an address one store depth above a written byte shows that addresses wrap.

// File: rtl/nvm_pkg.sv
// Shared constants for the store command controller: register offsets,
// command-word field positions and operation codes.
package nvm_pkg;
    localparam int REG_W    = 32;
    localparam int BUS_AW   = 4;
    localparam int BYTE_W   = 8;
    localparam int ADDR_W   = 13;
    localparam int BUSY_BIT = 31;
    localparam int OP_HI    = 29;
    localparam int OP_LO    = 28;
    localparam int TO_BIT   = 17;

    localparam logic [BUS_AW-1:0] CMD_OFS  = 4'h0;
    localparam logic [BUS_AW-1:0] DATA_OFS = 4'h4;

    typedef enum logic [1:0] {
        OP_READ  = 2'b00,
        OP_WRITE = 2'b11
    } nvm_op_e;
endpackage

// File: rtl/nvm_watchdog.sv
// Command watchdog. The counter restarts on start and counts each active
// cycle. expire is high during the LIMIT-th active cycle after start.
// Assumes active stays high from start until the command ends.
module nvm_watchdog #(
    parameter int LIMIT = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic active,
    output logic expire
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;

    // Restart on launch, advance while a command is outstanding.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (start)   cnt_q <= '0;
        else if (active)  cnt_q <= cnt_q + 1'b1;
    end

    assign expire = active && (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/nvm_store.sv
// Behavioural store backend: a byte array that acknowledges a request after
// a programmable number of wait cycles. It stays silent when not fitted.
// Dropping req abandons the access. The address wraps modulo DEPTH.
module nvm_store #(
    parameter int DEPTH  = 256,
    parameter int ADDR_W = 13,
    parameter int BYTE_W = 8,
    parameter int LAT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fitted,
    input  logic [LAT_W-1:0]  latency,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic              ack,
    output logic [BYTE_W-1:0] rdata
);
    localparam int IDX_W = $clog2(DEPTH);

    logic [BYTE_W-1:0] mem [DEPTH];
    logic [LAT_W-1:0]  wait_q;
    logic [IDX_W-1:0]  idx;
    logic              fire;

    assign idx  = addr[IDX_W-1:0];
    assign fire = req && !ack && fitted && (wait_q == latency);

    // Wait counter and one-cycle acknowledge pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || !req || ack) begin
            wait_q <= '0;
            ack    <= 1'b0;
        end else if (fire) begin
            ack    <= 1'b1;
        end else if (fitted) begin
            wait_q <= wait_q + 1'b1;
        end
    end

    // Array access in the cycle the acknowledge is raised.
    always_ff @(posedge clk) begin
        if (fire) begin
            if (we) mem[idx] <= wdata;
            else    rdata    <= mem[idx];
        end
    end
endmodule

// File: rtl/nvm_cmd_ctrl.sv
// Command/data register pair driving a byte store. A command write with the
// busy bit set launches an access. Busy self-clears on acknowledge or on
// watchdog expiry, and expiry also sets a sticky flag cleared by writing 1.
// Assumes single-cycle register writes and combinational register reads.
module nvm_cmd_ctrl
    import nvm_pkg::*;
#(
    parameter int TIMEOUT_CYCLES = 32,
    parameter int STORE_DEPTH    = 256,
    parameter int LAT_W          = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic              store_fitted,
    input  logic [LAT_W-1:0]  store_latency
);
    logic              busy_q, to_q;
    logic [1:0]        op_q;
    logic [ADDR_W-1:0] adr_q;
    logic [BYTE_W-1:0] data_q;
    logic              cmd_wr, data_wr, launch;
    logic              st_ack, wd_expire;
    logic [BYTE_W-1:0] st_rdata;

    assign cmd_wr  = bus_wr && (bus_addr == CMD_OFS);
    assign data_wr = bus_wr && (bus_addr == DATA_OFS);
    assign launch  = cmd_wr && !busy_q && bus_wdata[BUSY_BIT];

    nvm_watchdog #(.LIMIT(TIMEOUT_CYCLES)) u_wd (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (launch),
        .active (busy_q),
        .expire (wd_expire)
    );

    nvm_store #(
        .DEPTH  (STORE_DEPTH),
        .ADDR_W (ADDR_W),
        .BYTE_W (BYTE_W),
        .LAT_W  (LAT_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .fitted  (store_fitted),
        .latency (store_latency),
        .req     (busy_q),
        .we      (op_q == OP_WRITE),
        .addr    (adr_q),
        .wdata   (data_q),
        .ack     (st_ack),
        .rdata   (st_rdata)
    );

    // Opcode and address latch, accepted only while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q  <= '0;
            adr_q <= '0;
        end else if (cmd_wr && !busy_q) begin
            op_q  <= bus_wdata[OP_HI:OP_LO];
            adr_q <= bus_wdata[ADDR_W-1:0];
        end
    end

    // Busy: set by launch, cleared by acknowledge or watchdog expiry.
    always_ff @(posedge clk) begin
        if (!rst_n)                          busy_q <= 1'b0;
        else if (launch)                     busy_q <= 1'b1;
        else if (busy_q && (st_ack || wd_expire)) busy_q <= 1'b0;
    end

    // Sticky timeout flag; expiry takes priority over a write-one clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                             to_q <= 1'b0;
        else if (busy_q && !st_ack && wd_expire) to_q <= 1'b1;
        else if (cmd_wr && bus_wdata[TO_BIT])    to_q <= 1'b0;
    end

    // Data register: software loads it while idle, a completed read fills it.
    always_ff @(posedge clk) begin
        if (!rst_n)                                data_q <= '0;
        else if (data_wr && !busy_q)               data_q <= bus_wdata[BYTE_W-1:0];
        else if (busy_q && st_ack && op_q != OP_WRITE) data_q <= st_rdata;
    end

    // Register read multiplexer.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == CMD_OFS) begin
            bus_rdata[BUSY_BIT]     = busy_q;
            bus_rdata[OP_HI:OP_LO]  = op_q;
            bus_rdata[TO_BIT]       = to_q;
            bus_rdata[ADDR_W-1:0]   = adr_q;
        end else if (bus_addr == DATA_OFS) begin
            bus_rdata[BYTE_W-1:0]   = data_q;
        end
    end
endmodule

// File: rtl/nvm_cmd_ctrl_chk.sv
// Protocol checker for nvm_cmd_ctrl, attached by bind. It counts the cycles
// of each busy period to bound the watchdog without deep $past.
module nvm_cmd_ctrl_chk
    import nvm_pkg::*;
#(
    parameter int LIMIT = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              to_flag,
    input logic [ADDR_W-1:0] adr,
    input logic              bus_wr,
    input logic [BUS_AW-1:0] bus_addr,
    input logic [REG_W-1:0]  bus_wdata
);
    localparam int RW = $clog2(LIMIT + 2);

    logic [RW-1:0] run_q;

    // Length of the current busy period.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) run_q <= '0;
        else                 run_q <= run_q + 1'b1;
    end

    // R2
    busy_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(bus_wr && bus_addr == CMD_OFS && bus_wdata[BUSY_BIT]));

    // R5
    to_on_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(to_flag) |-> $fell(busy));

    // R5
    busy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_q < RW'(LIMIT)));

    // R6
    to_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(to_flag) |-> $past(bus_wr && bus_addr == CMD_OFS && bus_wdata[TO_BIT]));

    // R7
    adr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(adr));
endmodule

bind nvm_cmd_ctrl nvm_cmd_ctrl_chk #(.LIMIT(TIMEOUT_CYCLES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy_q),
    .to_flag   (to_q),
    .adr       (adr_q),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata)
);

// File: tb/tb_nvm_cmd_ctrl.sv
// Bench: a behavioural model updated on every rising edge and compared on
// every falling edge, plus directed checks tagged by requirement.
module tb_nvm_cmd_ctrl;
    localparam int LIMIT = 32;
    localparam int DEPTH = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = 4'h0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        store_fitted = 1'b1;
    logic [7:0]  store_latency = 8'd3;

    int n_tests = 0;
    int n_fail  = 0;

    nvm_cmd_ctrl #(.TIMEOUT_CYCLES(LIMIT), .STORE_DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .store_fitted(store_fitted), .store_latency(store_latency)
    );

    always #5 clk = ~clk;

    // Reference model state.
    bit        m_busy, m_to, m_ok;
    bit [1:0]  m_op;
    bit [12:0] m_adr;
    bit [7:0]  m_data;
    int        m_left;
    bit [7:0]  m_mem [int];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_to = 0; m_ok = 0; m_op = 0; m_adr = 0; m_data = 0; m_left = 0;
        end else begin
            bit bb;
            bb = m_busy;
            if (bb) begin
                m_left--;
                if (m_left == 0) begin
                    m_busy = 0;
                    if (m_ok) begin
                        if (m_op == 2'b11) m_mem[m_adr % DEPTH] = m_data;
                        else m_data = m_mem.exists(m_adr % DEPTH) ? m_mem[m_adr % DEPTH] : 8'h00;
                    end
                end
            end
            if (bus_wr && bus_addr == 4'h0) begin
                if (bus_wdata[17]) m_to = 0;
                if (!bb) begin
                    m_op  = bus_wdata[29:28];
                    m_adr = bus_wdata[12:0];
                    if (bus_wdata[31]) begin
                        m_busy = 1;
                        m_ok   = store_fitted && (int'(store_latency) + 2 <= LIMIT);
                        m_left = m_ok ? int'(store_latency) + 2 : LIMIT;
                    end
                end
            end
            if (bus_wr && bus_addr == 4'h4 && !bb) m_data = bus_wdata[7:0];
            if (bb && !m_busy && !m_ok) m_to = 1;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Per-cycle comparison of the addressed register (R4).
    always @(negedge clk) begin
        if (rst_n) begin
            logic [31:0] e;
            if (bus_addr == 4'h0) e = {m_busy, 1'b0, m_op, 10'b0, m_to, 4'b0, m_adr};
            else                  e = {24'b0, m_data};
            check("R4 per-cycle register", bus_rdata, e);
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0; bus_addr = 4'h0; bus_wdata = '0;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        bus_addr = 4'h0;
        forever begin
            @(negedge clk);
            if (bus_rdata[31]) n++;
            else break;
        end
    endtask

    task automatic read_reg(input logic [3:0] a, output logic [31:0] v);
        @(posedge clk); #1; bus_addr = a;
        @(negedge clk); v = bus_rdata;
        @(posedge clk); #1; bus_addr = 4'h0;
    endtask

    task automatic store_write(input logic [12:0] a, input logic [7:0] b, output int n);
        wr(4'h4, {24'b0, b});
        wr(4'h0, 32'h3002_0000 | a);
        wr(4'h0, 32'hB002_0000 | a);
        wait_idle(n);
    endtask

    task automatic store_read(input logic [12:0] a, output int n, output logic [31:0] d);
        wr(4'h0, 32'h8000_0000 | a);
        wait_idle(n);
        read_reg(4'h4, d);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int n;
        logic [31:0] v;
        repeat (3) @(posedge clk); #1;
        rst_n = 1'b1;

        read_reg(4'h0, v); check("R1 command after reset", v, 32'h0);
        read_reg(4'h4, v); check("R1 data after reset", v, 32'h0);

        // R11: busy clear latches fields only
        wr(4'h0, 32'h3000_0123);
        read_reg(4'h0, v); check("R11 latched without launch", v, 32'h3000_0123);

        // R2 / R3 write then read, latency 3
        store_latency = 8'd3;
        store_write(13'h010, 8'hA5, n); check("R2 busy length lat3 write", n, 5);
        read_reg(4'h0, v); check("R4 command after write", v, 32'h3000_0010);
        wr(4'h4, 32'h0000_0000);
        store_read(13'h010, n, v);
        check("R2 busy length lat3 read", n, 5);
        check("R3 read byte", v, 32'h0000_00A5);

        // latency 0
        store_latency = 8'd0;
        store_write(13'h011, 8'h3C, n); check("R2 busy length lat0", n, 2);
        store_read(13'h011, n, v); check("R3 read byte lat0", v, 32'h0000_003C);

        // R10 wrap
        store_read(13'h010 + DEPTH, n, v); check("R10 address wraps", v, 32'h0000_00A5);

        // acknowledge on the last watchdog cycle
        store_latency = 8'(LIMIT - 2);
        store_read(13'h010, n, v);
        check("R5 ack at limit busy length", n, LIMIT);
        read_reg(4'h0, v); check("R5 no timeout at limit", v[17], 1'b0);

        // R5 timeout
        wr(4'h4, 32'h0000_0011);
        store_latency = 8'(LIMIT + 8);
        store_read(13'h011, n, v);
        check("R5 busy length on timeout", n, LIMIT);
        check("R5 data kept on timeout", v, 32'h0000_0011);
        read_reg(4'h0, v); check("R5 timeout flag set", v[17], 1'b1);

        // R6 write zero keeps, write one clears
        wr(4'h0, 32'h0000_0011);
        read_reg(4'h0, v); check("R6 zero write keeps flag", v[17], 1'b1);
        wr(4'h0, 32'h0002_0011);
        read_reg(4'h0, v); check("R6 one write clears flag", v[17], 1'b0);

        // R9 probes
        store_fitted = 1'b0;
        wr(4'h0, 32'h8002_0000);
        wait_idle(n);
        read_reg(4'h0, v); check("R9 absent store probe", v[17], 1'b1);
        store_fitted = 1'b1; store_latency = 8'd3;
        wr(4'h0, 32'h8002_0000);
        wait_idle(n);
        read_reg(4'h0, v); check("R9 fitted store probe", v[17], 1'b0);

        // R7: timeout flag set, then launch without clearing it
        store_latency = 8'(LIMIT + 8);
        wr(4'h0, 32'h8000_0000); wait_idle(n);
        store_latency = 8'd20;
        wr(4'h4, 32'h0000_005A);
        wr(4'h0, 32'hB000_0020);
        wr(4'h0, 32'hB000_1FFF);
        read_reg(4'h0, v); check("R7 fields frozen while busy", v & 32'h3000_1FFF, 32'h3000_0020);
        check("R7 flag still set before clear", v[17], 1'b1);
        wr(4'h0, 32'h0002_0000);
        read_reg(4'h0, v); check("R7 clear allowed while busy", v[17], 1'b0);
        wr(4'h4, 32'h0000_0077);
        wait_idle(n);
        read_reg(4'h4, v); check("R8 data write ignored while busy", v, 32'h0000_005A);
        store_latency = 8'd1;
        wr(4'h4, 32'h0000_0000);
        store_read(13'h020, n, v); check("R8 stored byte unaffected", v, 32'h0000_005A);

        repeat (3) @(posedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule